// File: doc/BRIEF.md
# Two-Bank SDRAM Command Controller

This block converts single-word host requests into command sequences for a 16-bit synchronous DRAM with two banks. After reset it waits out a power-up interval, raises clock enable and runs the start-up sequence: precharge of all banks, two auto refreshes, and a mode-register load. It then serves host requests. Each access opens a row with ACTIVATE and then issues a READ or WRITE with auto-precharge set, so every access leaves its bank closed. A free-running interval counter raises a refresh request, and the controller serves that request before any host access waiting at the time.

The host side has a request channel and a read-data output. The request channel uses valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low during start-up, during a pending refresh, and from the acceptance of a request until that access and its precharge recovery are finished. While `req_ready` is low the host holds its request and must keep the request fields stable. The read-data output cannot be stalled, because the memory returns data on a fixed schedule. `rd_valid` marks each beat for exactly one cycle. A write stores one 16-bit word with a per-byte mask. A read returns `BURST_LEN` words in sequential order, wrapping inside the aligned burst block.

Top module: `sdram2b_ctrl`

## Requirements
- R1: While `rst_n` is low, `sd_cke` is 0, `sd_cs_n` is 1, `req_ready` is 0 and `rd_valid` is 0.
- R2: After reset the first command comes no earlier than `INIT_WAIT` cycles later. The first four commands are PRECHARGE with A10=1, AUTO REFRESH, AUTO REFRESH and LOAD MODE, in that order. `req_ready` stays low until all four have been issued.
- R3: The mode word on `sd_addr` has bit 9 = 1 (single-beat writes) and bits 6:4 = the CAS latency (2 when `cfg_cas3`=0, 3 when it is 1). Bit 3 = 0 (sequential). Bits 2:0 = log2(`BURST_LEN`). Every other bit is 0.
- R4: Commands are coded on {cs_n,ras_n,cas_n,we_n} as LOAD MODE 0000, REFRESH 0001, PRECHARGE 0010, ACTIVATE 0011, WRITE 0100, READ 0101, NOP 0111 and deselect 1111. No other code appears.
- R5: The host address splits as bank = bit 20, row = bits 19:9 and column = bits 8:0. ACTIVATE drives the bank on `sd_ba` and the row on `sd_addr`. READ/WRITE drive the same bank and the column on `sd_addr[8:0]`, with bit 10 = 1 (auto-precharge) and bit 9 = 0.
- R6: READ or WRITE follows its ACTIVATE exactly `T_RCD` cycles later on the pins.
- R7: A write is a single beat. In the WRITE cycle `sd_dq_oe`=1 and `sd_dq_out` holds the data. `sd_dqm` equals the mask, where bit 0 = 1 blocks the low byte and bit 1 = 1 blocks the high byte.
- R8: A READ is followed by `BURST_LEN` `rd_valid` beats. The first beat samples `sd_dq_in` CL+1 edges after the edge that drives READ. Beat b carries column (col & ~(BL-1)) | ((col+b) & (BL-1)).
- R9: An auto refresh is issued at least once per `REF_INTERVAL` cycles, plus the time to finish one access.
- R10: After a request is accepted, `req_ready` is low in the next cycle, and the next command on the pins is ACTIVATE.
- R11: `sd_dqm` is 00 in the READ cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_cas3 | input | 1 | CAS latency select, sampled at mode load: 0 = 2, 1 = 3 |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Word address {bank,row,column} |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Write byte mask, 1 = keep old byte |
| rd_valid | output | 1 | Read beat valid |
| rd_data | output | 16 | Read beat data |
| sd_cke | output | 1 | Memory clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 1 | Bank select |
| sd_addr | output | 11 | Row / column / mode address |
| sd_dqm | output | 2 | Byte masks |
| sd_dq_out | output | 16 | Write data to memory |
| sd_dq_oe | output | 1 | Data bus drive enable |
| sd_dq_in | input | 16 | Read data from memory |

## Verification
The bench writes, then reads back, columns 0–3 and 508–511 in both banks and in three rows (all zeros, all ones, alternating). The low columns and the top columns separate correct burst wrap inside the aligned block from a plain increment that crosses into the next block or past the row end. Writes rotate through all four byte masks, so a swapped or inverted mask shows up as a wrong byte when the word is read back. The whole sweep runs once at CAS latency 2 and once at 3, and the memory model uses the latency it decodes from the mode word. A capture that is off by one cycle, or that ignores the programmed latency, therefore returns a neighbouring beat instead of the expected one.

// File: rtl/sdram2b_pkg.sv
package sdram2b_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR  = 4'b0000,
    CMD_REF  = 4'b0001,
    CMD_PRE  = 4'b0010,
    CMD_ACT  = 4'b0011,
    CMD_WR   = 4'b0100,
    CMD_RD   = 4'b0101,
    CMD_NOP  = 4'b0111,
    CMD_DESL = 4'b1111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_POWERUP, ST_PRE, ST_REF1, ST_REF2, ST_MRS, ST_IDLE, ST_ACCESS
  } seq_state_e;
endpackage

// File: rtl/sdram2b_ref_timer.sv
module sdram2b_ref_timer #(
  parameter int INTERVAL = 3120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic pending
);
  localparam int CW = $clog2(INTERVAL + 1);

  logic [CW-1:0] cnt_q;
  logic          tick;

  assign tick = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= CW'(INTERVAL - 1);
      pending <= 1'b0;
    end else begin
      cnt_q <= tick ? CW'(INTERVAL - 1) : cnt_q - 1'b1;
      if (tick)      pending <= 1'b1;
      else if (ack)  pending <= 1'b0;
    end
  end

  AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !ack) |=> pending); // R9
endmodule

// File: rtl/sdram2b_rd_capture.sv
module sdram2b_rd_capture #(
  parameter int DW        = 16,
  parameter int BURST_LEN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cl3,
  input  logic [DW-1:0] dq_in,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  localparam int BW = $clog2(BURST_LEN + 1);

  logic [1:0]    wait_q;
  logic [BW-1:0] beats_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q   <= '0;
      beats_q  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (start) begin
        wait_q  <= cl3 ? 2'd3 : 2'd2;
        beats_q <= BW'(BURST_LEN);
      end else if (wait_q != '0) begin
        wait_q <= wait_q - 1'b1;
      end else if (beats_q != '0) begin
        rd_valid <= 1'b1;
        rd_data  <= dq_in;
        beats_q  <= beats_q - 1'b1;
      end
    end
  end

  AST_NO_READ_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (beats_q == '0 && wait_q == '0)); // R8
  AST_NO_EARLY_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !rd_valid); // R8
endmodule

// File: rtl/sdram2b_cmd_seq.sv
module sdram2b_cmd_seq
  import sdram2b_pkg::*;
#(
  parameter int ROW_W     = 11,
  parameter int COL_W     = 9,
  parameter int DW        = 16,
  parameter int BURST_LEN = 4,
  parameter int INIT_WAIT = 40000,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 14,
  parameter int T_MRD     = 2,
  parameter int T_RCD     = 3,
  parameter int T_WR      = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_cas3,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [ROW_W+COL_W:0]     req_addr,
  input  logic [DW-1:0]            req_wdata,
  input  logic [DW/8-1:0]          req_mask,
  input  logic                     ref_pend,
  output logic                     req_ready,
  output logic                     ref_ack,
  output logic                     rd_start,
  output logic                     cl3,
  output sd_cmd_e                  cmd,
  output logic                     cke,
  output logic                     ba,
  output logic [ROW_W-1:0]         addr,
  output logic [DW/8-1:0]          dqm,
  output logic [DW-1:0]            dq_out,
  output logic                     dq_oe
);
  localparam int AW     = ROW_W + COL_W + 1;
  localparam int AP_BIT = ROW_W - 1;
  localparam int MW     = DW / 8;
  localparam int RD_REC = 3 + BURST_LEN + T_RP;
  localparam int SHORT  = (T_RFC > RD_REC ? T_RFC : RD_REC) + T_WR + T_RP + T_RCD + T_MRD;
  localparam int TMAX   = INIT_WAIT > SHORT ? INIT_WAIT : SHORT;
  localparam int TW     = $clog2(TMAX + 1);
  localparam logic [2:0] BL_CODE = 3'($clog2(BURST_LEN));

  seq_state_e       state;
  logic [TW-1:0]    tmr;
  logic             lat_wr, lat_bank;
  logic [COL_W-1:0] lat_col;
  logic [DW-1:0]    lat_data;
  logic [MW-1:0]    lat_mask;
  logic             slot;
  logic [ROW_W-1:0] mode_word;

  assign slot      = (tmr == '0);
  assign req_ready = (state == ST_IDLE) && slot && !ref_pend;
  assign ref_ack   = (state == ST_IDLE) && slot && ref_pend;
  assign rd_start  = (state == ST_ACCESS) && slot && !lat_wr;

  always_comb begin
    mode_word      = '0;
    mode_word[9]   = 1'b1;
    mode_word[6:4] = cfg_cas3 ? 3'd3 : 3'd2;
    mode_word[2:0] = BL_CODE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_POWERUP;
      tmr      <= TW'(INIT_WAIT);
      cmd      <= CMD_DESL;
      cke      <= 1'b0;
      ba       <= 1'b0;
      addr     <= '0;
      dqm      <= '1;
      dq_out   <= '0;
      dq_oe    <= 1'b0;
      cl3      <= 1'b0;
      lat_wr   <= 1'b0;
      lat_bank <= 1'b0;
      lat_col  <= '0;
      lat_data <= '0;
      lat_mask <= '0;
    end else begin
      cmd   <= cke ? CMD_NOP : CMD_DESL;
      dq_oe <= 1'b0;
      dqm   <= (state == ST_IDLE || state == ST_ACCESS) ? '0 : '1;
      if (!slot) begin
        tmr <= tmr - 1'b1;
      end else begin
        unique case (state)
          ST_POWERUP: begin
            cke   <= 1'b1;
            tmr   <= TW'(1);
            state <= ST_PRE;
          end
          ST_PRE: begin
            cmd          <= CMD_PRE;
            addr         <= '0;
            addr[AP_BIT] <= 1'b1;
            tmr          <= TW'(T_RP - 1);
            state        <= ST_REF1;
          end
          ST_REF1: begin
            cmd   <= CMD_REF;
            tmr   <= TW'(T_RFC - 1);
            state <= ST_REF2;
          end
          ST_REF2: begin
            cmd   <= CMD_REF;
            tmr   <= TW'(T_RFC - 1);
            state <= ST_MRS;
          end
          ST_MRS: begin
            cmd   <= CMD_LMR;
            ba    <= 1'b0;
            addr  <= mode_word;
            cl3   <= cfg_cas3;
            tmr   <= TW'(T_MRD - 1);
            state <= ST_IDLE;
          end
          ST_IDLE: begin
            if (ref_pend) begin
              cmd <= CMD_REF;
              tmr <= TW'(T_RFC - 1);
            end else if (req_valid) begin
              lat_wr   <= req_write;
              lat_bank <= req_addr[AW-1];
              lat_col  <= req_addr[COL_W-1:0];
              lat_data <= req_wdata;
              lat_mask <= req_mask;
              cmd      <= CMD_ACT;
              ba       <= req_addr[AW-1];
              addr     <= req_addr[AW-2:COL_W];
              tmr      <= TW'(T_RCD - 1);
              state    <= ST_ACCESS;
            end
          end
          ST_ACCESS: begin
            ba                 <= lat_bank;
            addr               <= '0;
            addr[AP_BIT]       <= 1'b1;
            addr[COL_W-1:0]    <= lat_col;
            state              <= ST_IDLE;
            if (lat_wr) begin
              cmd    <= CMD_WR;
              dq_out <= lat_data;
              dq_oe  <= 1'b1;
              dqm    <= lat_mask;
              tmr    <= TW'(T_WR + T_RP - 1);
            end else begin
              cmd <= CMD_RD;
              tmr <= cl3 ? TW'(RD_REC - 1) : TW'(RD_REC - 2);
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_ACCEPT_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (cmd == CMD_ACT && ba == $past(req_addr[AW-1]))); // R10
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R10
  AST_RW_AUTOPRE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_RD || cmd == CMD_WR) |-> addr[AP_BIT]); // R5
  AST_READY_AFTER_CKE: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> !req_ready); // R2
  AST_RD_DQM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_RD) |-> (dqm == '0)); // R11
endmodule

// File: rtl/sdram2b_ctrl.sv
module sdram2b_ctrl
  import sdram2b_pkg::*;
#(
  parameter int ROW_W        = 11,
  parameter int COL_W        = 9,
  parameter int DW           = 16,
  parameter int BURST_LEN    = 4,
  parameter int INIT_WAIT    = 40000,
  parameter int REF_INTERVAL = 3120,
  parameter int T_RP         = 3,
  parameter int T_RFC        = 14,
  parameter int T_MRD        = 2,
  parameter int T_RCD        = 3,
  parameter int T_WR         = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_cas3,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W:0]   req_addr,
  input  logic [DW-1:0]          req_wdata,
  input  logic [DW/8-1:0]        req_mask,
  output logic                   rd_valid,
  output logic [DW-1:0]          rd_data,
  output logic                   sd_cke,
  output logic                   sd_cs_n,
  output logic                   sd_ras_n,
  output logic                   sd_cas_n,
  output logic                   sd_we_n,
  output logic                   sd_ba,
  output logic [ROW_W-1:0]       sd_addr,
  output logic [DW/8-1:0]        sd_dqm,
  output logic [DW-1:0]          sd_dq_out,
  output logic                   sd_dq_oe,
  input  logic [DW-1:0]          sd_dq_in
);
  logic    ref_pend, ref_ack, rd_start, cl3;
  sd_cmd_e cmd;

  sdram2b_ref_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
    .clk(clk), .rst_n(rst_n), .ack(ref_ack), .pending(ref_pend)
  );

  sdram2b_cmd_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DW(DW), .BURST_LEN(BURST_LEN),
    .INIT_WAIT(INIT_WAIT), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD),
    .T_RCD(T_RCD), .T_WR(T_WR)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg_cas3(cfg_cas3),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_mask(req_mask), .ref_pend(ref_pend),
    .req_ready(req_ready), .ref_ack(ref_ack), .rd_start(rd_start), .cl3(cl3),
    .cmd(cmd), .cke(sd_cke), .ba(sd_ba), .addr(sd_addr), .dqm(sd_dqm),
    .dq_out(sd_dq_out), .dq_oe(sd_dq_oe)
  );

  sdram2b_rd_capture #(.DW(DW), .BURST_LEN(BURST_LEN)) u_cap (
    .clk(clk), .rst_n(rst_n), .start(rd_start), .cl3(cl3),
    .dq_in(sd_dq_in), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

  AST_WR_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe |-> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0100)); // R7
endmodule

// File: tb/sdram2b_ctrl_tb.sv
module sdram2b_ctrl_tb;
  localparam int INIT_WAIT = 30;
  localparam int REF_INT   = 150;
  localparam int T_RCD     = 2;
  localparam int BL        = 4;
  // R4 command codes {cs_n,ras_n,cas_n,we_n}
  localparam logic [3:0] C_LMR = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
    C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101, C_NOP = 4'b0111, C_DESL = 4'b1111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_cas3 = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [20:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic req_ready, rd_valid;
  logic [15:0] rd_data;
  logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_dq_oe;
  logic [10:0] sd_addr;
  logic [1:0]  sd_dqm;
  logic [15:0] sd_dq_out;
  logic [15:0] sd_dq_in = '0;

  always #2.5 clk = ~clk;

  sdram2b_ctrl #(
    .BURST_LEN(BL), .INIT_WAIT(INIT_WAIT), .REF_INTERVAL(REF_INT),
    .T_RP(2), .T_RFC(6), .T_MRD(2), .T_RCD(T_RCD), .T_WR(2)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_cas3(cfg_cas3),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm),
    .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
  );

  int errors = 0, checks = 0, cyc = 0, rst_cyc = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [15:0] bg(input logic [20:0] a);
    return a[15:0] ^ 16'hC3A5;
  endfunction

  // memory model driven only from the pins
  logic [15:0] mem [logic [20:0]];
  logic [15:0] exp_mem [logic [20:0]];
  logic [10:0] open_row [2];
  logic [15:0] dly [16];
  bit          dly_v [16];
  logic [3:0]  init_seq [4];
  int init_idx = 0, first_cyc = 0, act_cyc = 0, mode_cl = 2, bad_cmd = 0;
  int refs = 0, last_ref = 0, max_gap = 0;
  bit pre_a10 = 1'b0, act_ba = 1'b0, mode_seen = 1'b0, ref_seen = 1'b0;
  logic [3:0] cmd;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    if (rst_n) begin
      if (cmd != C_NOP && cmd != C_DESL && init_idx < 4) begin
        if (init_idx == 0) begin first_cyc = cyc - rst_cyc; pre_a10 = sd_addr[10]; end
        init_seq[init_idx] = cmd;
        init_idx++;
      end
      case (cmd)
        C_LMR: begin
          logic [10:0] em;
          em = {1'b0, 1'b1, 2'b00, (cfg_cas3 ? 3'd3 : 3'd2), 1'b0, 3'd2};
          chk(sd_addr == em && sd_ba == 1'b0, "R3 mode word", sd_addr, em);
          mode_cl = int'(sd_addr[6:4]);
          mode_seen = 1'b1;
        end
        C_ACT: begin open_row[sd_ba] = sd_addr; act_cyc = cyc; act_ba = sd_ba; end
        C_RD, C_WR: begin
          logic [8:0] col;
          logic [20:0] a;
          col = sd_addr[8:0];
          chk(sd_addr[10:9] == 2'b10, "R5 A10/A9 on access", sd_addr[10:9], 2);
          chk(sd_ba == act_ba, "R5 bank on access", sd_ba, act_ba);
          chk(cyc - act_cyc == T_RCD, "R6 ACT to access gap", cyc - act_cyc, T_RCD);
          a = {sd_ba, open_row[sd_ba], col};
          if (cmd == C_WR) begin
            logic [15:0] old;
            chk(sd_dq_oe == 1'b1, "R7 bus drive on write", sd_dq_oe, 1);
            old = mem.exists(a) ? mem[a] : bg(a);
            mem[a] = {sd_dqm[1] ? old[15:8] : sd_dq_out[15:8],
                      sd_dqm[0] ? old[7:0]  : sd_dq_out[7:0]};
          end else begin
            chk(sd_dqm == 2'b00, "R11 dqm on read", sd_dqm, 0);
            for (int b = 0; b < BL; b++) begin
              logic [20:0] ab;
              ab = {a[20:9], (col & ~9'(BL-1)) | ((col + 9'(b)) & 9'(BL-1))};
              dly[mode_cl + b] = mem.exists(ab) ? mem[ab] : bg(ab);
              dly_v[mode_cl + b] = 1'b1;
            end
          end
        end
        C_REF: begin
          if (mode_seen) begin
            if (ref_seen && cyc - last_ref > max_gap) max_gap = cyc - last_ref;
            ref_seen = 1'b1;
            last_ref = cyc;
            refs++;
          end
        end
        C_PRE, C_NOP, C_DESL: ;
        default: bad_cmd++;
      endcase
      sd_dq_in = dly_v[0] ? dly[0] : 16'hDEAD;
      for (int i = 0; i < 15; i++) begin dly[i] = dly[i+1]; dly_v[i] = dly_v[i+1]; end
      dly_v[15] = 1'b0;
    end
  end

  task automatic start_phase(input bit cl3);
    rst_n = 1'b0;
    cfg_cas3 = cl3;
    mem.delete();
    exp_mem.delete();
    init_idx = 0; mode_seen = 0; ref_seen = 0; refs = 0; max_gap = 0; bad_cmd = 0;
    for (int i = 0; i < 16; i++) dly_v[i] = 1'b0;
    repeat (4) @(negedge clk);
    chk(sd_cke == 0 && sd_cs_n == 1 && req_ready == 0 && rd_valid == 0, "R1 reset state",
        {sd_cke, sd_cs_n, req_ready, rd_valid}, 4'b0100);
    rst_n = 1'b1;
    rst_cyc = cyc;
    while (!req_ready) @(negedge clk);
    chk(init_idx == 4, "R2 commands before ready", init_idx, 4);
    chk(init_seq[0] == C_PRE && pre_a10, "R2 first is precharge all", init_seq[0], C_PRE);
    chk(init_seq[1] == C_REF && init_seq[2] == C_REF, "R2 two refreshes",
        {init_seq[1], init_seq[2]}, {C_REF, C_REF});
    chk(init_seq[3] == C_LMR, "R2 mode load fourth", init_seq[3], C_LMR);
    chk(first_cyc >= INIT_WAIT, "R2 power-up wait", first_cyc, INIT_WAIT);
  endtask

  task automatic issue(input bit wr, input logic [20:0] a, input logic [15:0] d, input logic [1:0] m);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10 busy after accept", req_ready, 0);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_ACT, "R10 activate follows accept",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_ACT);
    chk(sd_ba == a[20] && sd_addr == a[19:9], "R5 activate bank/row", {sd_ba, sd_addr}, a[20:9]);
  endtask

  task automatic do_write(input logic [20:0] a, input logic [15:0] d, input logic [1:0] m);
    logic [15:0] old;
    issue(1'b1, a, d, m);
    old = exp_mem.exists(a) ? exp_mem[a] : bg(a);
    exp_mem[a] = {m[1] ? old[15:8] : d[15:8], m[0] ? old[7:0] : d[7:0]};
  endtask

  task automatic do_read(input logic [20:0] a);
    int got = 0;
    issue(1'b0, a, 16'h0, 2'b00);
    for (int t = 0; t < 40 && got < BL; t++) begin
      @(negedge clk);
      if (rd_valid) begin
        logic [20:0] ab;
        logic [15:0] e;
        ab = {a[20:9], (a[8:0] & ~9'(BL-1)) | ((a[8:0] + 9'(got)) & 9'(BL-1))};
        e = exp_mem.exists(ab) ? exp_mem[ab] : bg(ab);
        chk(rd_data == e, cfg_cas3 ? "R8 read beat CL3" : "R8 read beat CL2", rd_data, e);
        got++;
      end
    end
    chk(got == BL, "R8 beat count", got, BL);
  endtask

  task automatic sweep();
    logic [10:0] rows [3];
    logic [8:0]  cols [8];
    int k = 0;
    rows = '{11'h000, 11'h7FF, 11'h555};
    cols = '{9'd0, 9'd1, 9'd2, 9'd3, 9'd508, 9'd509, 9'd510, 9'd511};
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < 3; r++)
        for (int c = 0; c < 8; c++) begin
          logic [20:0] a;
          a = {1'(b), rows[r], cols[c]};
          do_write(a, 16'(int'(a) * 40503 + k), 2'(k));
          k++;
        end
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < 3; r++)
        for (int c = 0; c < 8; c++) do_read({1'(b), rows[r], cols[c]});
  endtask

  task automatic end_phase(input int start_cyc);
    int span;
    repeat (REF_INT) @(negedge clk);
    span = cyc - start_cyc;
    chk(refs >= span / REF_INT - 1, "R9 refresh count", refs, span / REF_INT - 1);
    chk(max_gap <= REF_INT + 20, "R9 refresh gap", max_gap, REF_INT + 20);
    chk(bad_cmd == 0, "R4 illegal command codes", bad_cmd, 0);
  endtask

  initial begin
    int s;
    for (int cl = 0; cl < 2; cl++) begin
      start_phase(1'(cl));
      s = cyc;
      sweep();
      end_phase(s);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule